// File: doc/BRIEF.md
# Shared Bus Holder

This block stands in for an on-chip bus that several sources would normally drive through tri-state buffers. Each of N sources presents a data word and an enable. In any clock cycle where one or more enables are high, the bus takes the data of the winning source. When every enable is low, the bus keeps showing the word it last carried, the way a released tri-state net keeps its charge. A consumer whose strobe arrives several cycles after the driver has let go therefore still samples the right value.

The design is fully synchronous. Each source's word is first registered into a holding register of its own. A separately stored owner index then selects among those held words. The output multiplexer is never steered by a live enable, so the value on the bus cannot race with the enable that captured it. There are no latches and no high-impedance nets.

When several enables are high together, the lowest-numbered source wins. A contention flag marks the cycle that follows such a clash.

Top module: `shared_bus_hold`

## Requirements
- R1: A synchronous active-high reset drives `bus_out` to zero and `contention` low, and makes source 0 the owner. With no enable after reset, `bus_out` stays zero. This also holds when reset is asserted after bus activity.
- R2: If exactly one enable `src_en[i]` is high at a clock edge, `bus_out` equals the `src_data[i]` sampled at that edge from the next cycle on.
- R3: While all enables are low, `bus_out` and the stored owner index do not change, for any number of cycles.
- R4: After idle cycles, the bus shows the last driver's word, including the highest-index source. It never falls back to source 0 or to any other default source.
- R5: When two or more enables are high at an edge, the bus takes the data of the lowest-index enabled source.
- R6: `contention` is high for exactly the one cycle after an edge at which two or more enables were high. It is low after any edge at which zero or one enable was high.
- R7: Changes on the data of a source whose enable is low have no effect on `bus_out`.
- R8: While a source's enable stays high, `bus_out` follows that source's data with one cycle of delay, cycle by cycle.
- R9: When ownership passes between sources on consecutive edges, `bus_out` shows each owner's word in turn, with no cycle of a stale or default value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| src_en | input | N | Per-source drive enable; bit i belongs to source i |
| src_data | input | N x W | Per-source data word; element i belongs to source i |
| bus_out | output | W | Resolved bus value, held while no source drives |
| contention | output | 1 | High for the cycle after two or more enables were sampled high |

## Verification
The bench aims at the idle gap after a driver releases the bus. A design that muxed on the live enables would fall back to a default source there, so the bench waits several cycles and then samples. It drives the highest-index source before going idle, because a fallback to source 0 or to the last index would otherwise hide behind a matching value. It also toggles the data of disabled sources, which exposes a design that captures without qualifying on the enable. The clash cases check both the winner's data and the one-cycle width of the contention flag, which catch a reversed priority or a sticky flag. Back-to-back handovers catch an owner register that updates one cycle late.

// File: rtl/shared_bus_pkg.sv
package shared_bus_pkg;

  localparam int unsigned MAX_SOURCES = 64;

  typedef logic [MAX_SOURCES-1:0] src_vec_t;

  // Index of the lowest set bit; zero when none is set.
  function automatic logic [5:0] lowest_set(input src_vec_t v);
    logic [5:0] idx;
    idx = '0;
    for (int k = MAX_SOURCES - 1; k >= 0; k--) begin
      if (v[k]) idx = 6'(k);
    end
    return idx;
  endfunction

  // Number of set bits.
  function automatic logic [6:0] count_set(input src_vec_t v);
    logic [6:0] n;
    n = '0;
    for (int k = 0; k < MAX_SOURCES; k++) begin
      n = n + 7'(v[k]);
    end
    return n;
  endfunction

endpackage

// File: rtl/hold_bank.sv
module hold_bank #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        cap_en,
  input  logic [N-1:0][W-1:0] cap_data,
  output logic [N-1:0][W-1:0] held
);

  // One holding register per source, loaded only when that source drives.
  for (genvar g = 0; g < N; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        held[g] <= '0;
      end else if (cap_en[g]) begin
        held[g] <= cap_data[g];
      end
    end
  end

endmodule

// File: rtl/owner_tracker.sv
module owner_tracker
  import shared_bus_pkg::*;
#(
  parameter int unsigned N  = 4,
  parameter int unsigned SW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  output logic [SW-1:0] owner_q,
  output logic          clash_q,
  output logic          any_req,
  output logic          clash_now
);

  logic [SW-1:0] winner;

  always_comb begin
    any_req   = |req;
    winner    = SW'(lowest_set(src_vec_t'(req)));
    clash_now = count_set(src_vec_t'(req)) > 7'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q <= '0;
      clash_q <= 1'b0;
    end else begin
      clash_q <= clash_now;
      if (any_req) owner_q <= winner;
    end
  end

endmodule

// File: rtl/held_mux.sv
module held_mux #(
  parameter int unsigned N  = 4,
  parameter int unsigned W  = 8,
  parameter int unsigned SW = 2
) (
  input  logic [N-1:0][W-1:0] held,
  input  logic [SW-1:0]       pick,
  output logic [W-1:0]        y
);

  always_comb begin
    y = '0;
    for (int k = 0; k < N; k++) begin
      if (pick == SW'(k)) y = held[k];
    end
  end

endmodule

// File: rtl/shared_bus_hold.sv
module shared_bus_hold #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        src_en,
  input  logic [N-1:0][W-1:0] src_data,
  output logic [W-1:0]        bus_out,
  output logic                contention
);

  localparam int unsigned SW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0][W-1:0] held;
  logic [SW-1:0]       sel_q;
  logic                any_en;
  logic                clash_now;

  hold_bank #(.N(N), .W(W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .cap_en   (src_en),
    .cap_data (src_data),
    .held     (held)
  );

  owner_tracker #(.N(N), .SW(SW)) u_owner (
    .clk       (clk),
    .rst       (rst),
    .req       (src_en),
    .owner_q   (sel_q),
    .clash_q   (contention),
    .any_req   (any_en),
    .clash_now (clash_now)
  );

  held_mux #(.N(N), .W(W), .SW(SW)) u_mux (
    .held (held),
    .pick (sel_q),
    .y    (bus_out)
  );

endmodule

// File: rtl/shared_bus_hold_chk.sv
module shared_bus_hold_chk #(
  parameter int unsigned N  = 4,
  parameter int unsigned W  = 8,
  parameter int unsigned SW = 2
) (
  input logic                clk,
  input logic                rst,
  input logic [N-1:0]        src_en,
  input logic [N-1:0][W-1:0] src_data,
  input logic [W-1:0]        bus_out,
  input logic                contention,
  input logic [SW-1:0]       sel_q,
  input logic                any_en,
  input logic                clash_now
);

  localparam logic [N-1:0] TOP_ONLY = N'(1) << (N - 1);

  assert_idle_bus_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (src_en == '0) |=> $stable(bus_out));

  assert_idle_owner_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (src_en == '0) |=> $stable(sel_q));

  assert_src0_wins_R5: assert property (@(posedge clk) disable iff (rst)
    src_en[0] |=> (bus_out == $past(src_data[0])));

  assert_top_alone_passes_R2: assert property (@(posedge clk) disable iff (rst)
    (src_en == TOP_ONLY) |=> (bus_out == $past(src_data[N-1])));

  assert_clash_flag_R6: assert property (@(posedge clk) disable iff (rst)
    ($countones(src_en) > 1) |=> contention);

  assert_no_clash_flag_R6: assert property (@(posedge clk) disable iff (rst)
    ($countones(src_en) <= 1) |=> !contention);

  assert_any_en_matches_R2: assert property (@(posedge clk) disable iff (rst)
    any_en == (src_en != '0));

  assert_clash_now_R6: assert property (@(posedge clk) disable iff (rst)
    clash_now |-> !$onehot0(src_en));

endmodule

bind shared_bus_hold shared_bus_hold_chk #(.N(N), .W(W), .SW(SW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .src_en     (src_en),
  .src_data   (src_data),
  .bus_out    (bus_out),
  .contention (contention),
  .sel_q      (sel_q),
  .any_en     (any_en),
  .clash_now  (clash_now)
);

// File: tb/tb_shared_bus_hold.sv
`timescale 1ns/1ps
module tb_shared_bus_hold;

  localparam int unsigned N = 4;
  localparam int unsigned W = 8;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [N-1:0]        src_en = '0;
  logic [N-1:0][W-1:0] src_data = '0;
  logic [W-1:0]        bus_out;
  logic                contention;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  shared_bus_hold #(.N(N), .W(W)) dut (
    .clk(clk), .rst(rst), .src_en(src_en), .src_data(src_data),
    .bus_out(bus_out), .contention(contention)
  );

  // Advance one edge, then settle away from it.
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_bus(input string req, input logic [W-1:0] exp);
    compared++;
    if (bus_out !== exp) begin
      mismatched++;
      $display("FAIL %s: bus_out got %h expected %h", req, bus_out, exp);
    end
  endtask

  task automatic chk_flag(input string req, input logic exp);
    compared++;
    if (contention !== exp) begin
      mismatched++;
      $display("FAIL %s: contention got %b expected %b", req, contention, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; src_en = '0;
    step(); step();
    chk_bus("R1", 8'h00); chk_flag("R1", 1'b0);
    rst = 1'b0;
    step(); step();
    chk_bus("R1", 8'h00); chk_flag("R1", 1'b0);
  endtask

  task automatic t_single_hold();
    src_data[1] = 8'h5A; src_en = 4'b0010;
    step();
    chk_bus("R2", 8'h5A); chk_flag("R6", 1'b0);
    src_en = '0; src_data[1] = 8'hFF;
    for (int k = 0; k < 5; k++) begin
      step();
      chk_bus("R3", 8'h5A);
    end
  endtask

  task automatic t_no_default();
    src_data[3] = 8'hC3; src_en = 4'b1000;
    step();
    chk_bus("R2", 8'hC3);
    src_en = '0;
    for (int k = 0; k < 4; k++) begin
      src_data = {8'h10 + 8'(k), 8'h20 + 8'(k), 8'h30 + 8'(k), 8'h40 + 8'(k)};
      step();
      chk_bus("R4", 8'hC3);
    end
  endtask

  task automatic t_priority();
    src_data = {8'h44, 8'h22, 8'h11, 8'h00};
    src_en = 4'b0110;
    step();
    chk_bus("R5", 8'h11); chk_flag("R6", 1'b1);
    src_en = '0;
    step();
    chk_bus("R5", 8'h11); chk_flag("R6", 1'b0);
    src_data[0] = 8'hE0; src_en = 4'b1111;
    step();
    chk_bus("R5", 8'hE0); chk_flag("R6", 1'b1);
    src_en = 4'b0100;
    step();
    chk_bus("R2", 8'h22); chk_flag("R6", 1'b0);
  endtask

  task automatic t_ignore();
    src_data[2] = 8'h77; src_en = 4'b0100;
    step();
    chk_bus("R7", 8'h77);
    src_data[1] = 8'h99; src_data[3] = 8'h66;
    step();
    chk_bus("R7", 8'h77);
    src_en = '0; src_data[0] = 8'h01;
    step();
    chk_bus("R7", 8'h77);
  endtask

  task automatic t_stream();
    src_en = 4'b0001;
    for (int k = 0; k < 4; k++) begin
      src_data[0] = 8'hA0 + 8'(k);
      step();
      chk_bus("R8", 8'hA0 + 8'(k));
    end
    src_en = '0;
    step();
    chk_bus("R8", 8'hA3);
  endtask

  task automatic t_switch();
    src_data = {8'hB3, 8'hB2, 8'hB1, 8'hA1};
    src_en = 4'b0001;
    step(); chk_bus("R9", 8'hA1);
    src_en = 4'b1000;
    step(); chk_bus("R9", 8'hB3);
    src_en = 4'b0010;
    step(); chk_bus("R9", 8'hB1);
    src_en = '0;
    step(); chk_bus("R9", 8'hB1);
  endtask

  task automatic t_mid_reset();
    src_data[2] = 8'h5C; src_en = 4'b0110;
    step();
    rst = 1'b1; src_en = '0;
    step();
    chk_bus("R1", 8'h00); chk_flag("R1", 1'b0);
    rst = 1'b0;
    step();
    chk_bus("R1", 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    t_reset();
    t_single_hold();
    t_no_default();
    t_priority();
    t_ignore();
    t_stream();
    t_switch();
    t_mid_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule